// File: doc/BRIEF.md
# Variable Length Instruction Decoder

This block turns one 16-bit instruction word into a decoded bundle for the execution stage. It sorts the word into one of three encoding formats by its top two bits and pulls out the operation code, register indices, an 8-bit unsigned value and a scaled branch displacement. It flags undefined codes as illegal. It reports whether the instruction is 2 or 6 bytes long. A 6-byte instruction carries a 32-bit immediate in the four bytes after the word, and the fetch unit must collect it.

The fetch stage presents a word with a one-cycle `in_valid` strobe. The bundle is registered and appears with `out_done` one clock later. The bundle then holds its value until the next strobe. Each instruction gets a one-hot class and an exception code, so the issue logic needs no second decode.

Top module: `vl_instr_decoder`

## Requirements
- R1: `out_fmt` is 1 when word bit 15 is 0, 2 when bits 15:14 are 10, and 3 when bits 15:14 are 11.
- R2: In format 1, `out_op` is bits 15:8, `out_ra` is bits 7:4, `out_rb` is bits 3:0, and `out_imm8` and `out_disp` are 0.
- R3: In format 2, `out_op` is bits 13:12 zero-extended, `out_ra` is bits 11:8, `out_imm8` is bits 7:0, and `out_rb` and `out_disp` are 0. Codes 0 and 1 (add or subtract the value) have class alu. Codes 2 and 3 (read or write a special register) have class special-register.
- R4: In format 3, `out_op` is bits 13:10 zero-extended. `out_disp` is bits 9:0 sign-extended to 16 bits and shifted left by one. `out_ra`, `out_rb` and `out_imm8` are 0.
- R5: Format 1 codes 0x00–0x0E and 0x19–0x39 are legal, and every other format 1 code is illegal. Format 3 codes 0–9 are legal and codes 10–15 are illegal. All format 2 codes are legal. An illegal word sets `out_illegal`, class exception, exception code 1 and length 2.
- R6: `out_len` is 6 and `out_need_imm` is 1 for format 1 codes 0x01, 0x03, 0x08, 0x09, 0x0C, 0x0D, 0x1A, 0x1B, 0x1D, 0x1F, 0x20, 0x22, 0x24, 0x30 and 0x36–0x39. For all other words `out_len` is 2 and `out_need_imm` is 0.
- R7: `out_cls` is one-hot. The bits are: 0 alu, 1 load, 2 store, 3 branch, 4 jump, 5 call, 6 return, 7 special-register, 8 exception. For legal format 1 codes the classes are:
  - load: 0x07, 0x08, 0x0A, 0x0C, 0x1C, 0x1D, 0x21, 0x22, 0x36, 0x38
  - store: 0x06, 0x09, 0x0B, 0x0D, 0x1E, 0x1F, 0x23, 0x24, 0x37, 0x39
  - call: 0x03, 0x19
  - return: 0x04
  - jump: 0x1A, 0x25
  - exception: 0x30, 0x35
  - alu: every other legal code

  Legal format 3 words have class branch.
- R8: `out_exc` is 2 for format 1 code 0x30 (software interrupt), 3 for code 0x35 (breakpoint), 1 for illegal words and 0 otherwise.
- R9: `out_shift5` is 1 only for format 1 codes 0x27, 0x28 and 0x2D. It marks that the datapath must use only the low 5 bits of the amount register.
- R10: `out_done` is high for exactly the cycle after each cycle in which `in_valid` is high. Without a strobe, the bundle keeps its previous value.
- R11: After reset, `out_done` is 0 and every bundle output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Word strobe |
| in_word | input | 16 | Instruction word |
| out_done | output | 1 | Bundle updated this cycle |
| out_fmt | output | 2 | Format 1, 2 or 3 |
| out_op | output | 8 | Operation code of the format |
| out_ra | output | 4 | First register index |
| out_rb | output | 4 | Second register index |
| out_imm8 | output | 8 | Unsigned 8-bit value (format 2) |
| out_disp | output | 16 | Branch byte displacement (format 3) |
| out_cls | output | 9 | One-hot operation class |
| out_len | output | 3 | Instruction length in bytes |
| out_need_imm | output | 1 | A 32-bit immediate follows |
| out_illegal | output | 1 | Undefined encoding |
| out_exc | output | 2 | Exception code |
| out_shift5 | output | 1 | Shift amount uses low 5 bits |

## Verification
The bench sweeps all 128 format 1 codes. This catches a table that is off by one at the edges of the legal ranges: 0x0E/0x0F, 0x18/0x19 and 0x39/0x3A. Such a table would let an undefined code execute or would trap a real one. It drives format 3 words at codes 9 and 10 and displacements of 0x1FF and 0x200. A wrong sign extension or a missing scale would send taken branches to the wrong address. Random words checked against bench functions catch a field taken from the wrong bits or a misstated length, and a misstated length would make the fetch unit misalign every later instruction. Idle gaps between strobes show whether the bundle holds and whether `out_done` pulses only once.

// File: rtl/vlid_pkg.sv
// Package: shared widths, class bit positions, exception codes and the
// attribute record produced by the opcode tables.
package vlid_pkg;
    localparam int WORD_W   = 16;
    localparam int REG_W    = 4;
    localparam int OP_W     = 8;
    localparam int IMM8_W   = 8;
    localparam int DISP_W   = 16;
    localparam int NCLS     = 9;
    localparam int LEN_W    = 3;

    localparam int CLS_ALU   = 0;
    localparam int CLS_LOAD  = 1;
    localparam int CLS_STORE = 2;
    localparam int CLS_BR    = 3;
    localparam int CLS_JUMP  = 4;
    localparam int CLS_CALL  = 5;
    localparam int CLS_RET   = 6;
    localparam int CLS_SREG  = 7;
    localparam int CLS_EXC   = 8;

    typedef enum logic [1:0] {
        FMT_NONE  = 2'd0,
        FMT_ONE   = 2'd1,
        FMT_TWO   = 2'd2,
        FMT_THREE = 2'd3
    } fmt_e;

    typedef enum logic [1:0] {
        EXC_NONE    = 2'd0,
        EXC_ILLEGAL = 2'd1,
        EXC_SWI     = 2'd2,
        EXC_BREAK   = 2'd3
    } exc_e;

    typedef struct packed {
        logic [NCLS-1:0] cls;
        logic            long_form;
        logic            legal;
        exc_e            exc;
        logic            shift5;
    } op_attr_t;

    // Attribute record for an undefined encoding.
    function automatic op_attr_t illegal_attr();
        op_attr_t a;
        a.cls       = '0;
        a.cls[CLS_EXC] = 1'b1;
        a.long_form = 1'b0;
        a.legal     = 1'b0;
        a.exc       = EXC_ILLEGAL;
        a.shift5    = 1'b0;
        return a;
    endfunction
endpackage

// File: rtl/vlid_field_split.sv
// Field splitter: picks the format from the top bits of the word and
// extracts operation code, register indices, 8-bit value and the scaled
// branch displacement. Purely combinational; assumes nothing about legality.
module vlid_field_split
    import vlid_pkg::*;
#(
    parameter int W        = WORD_W,
    parameter int DW       = DISP_W,
    parameter int BR_OFS_W = 10
) (
    input  logic [W-1:0]      word,
    output fmt_e              fmt,
    output logic [OP_W-1:0]   op,
    output logic [REG_W-1:0]  ra,
    output logic [REG_W-1:0]  rb,
    output logic [IMM8_W-1:0] imm8,
    output logic [DW-1:0]     disp
);
    localparam int EXT_W = DW - BR_OFS_W - 1;

    logic [DW-1:0] disp_scaled;

    // Sign-extend the branch offset field and scale it to bytes.
    always_comb begin
        disp_scaled = {{EXT_W{word[BR_OFS_W-1]}}, word[BR_OFS_W-1:0], 1'b0};
    end

    // Format selection and field extraction per format.
    always_comb begin
        fmt  = FMT_NONE;
        op   = '0;
        ra   = '0;
        rb   = '0;
        imm8 = '0;
        disp = '0;
        if (!word[W-1]) begin
            fmt = FMT_ONE;
            op  = word[W-1 -: OP_W];
            ra  = word[7:4];
            rb  = word[3:0];
        end else if (!word[W-2]) begin
            fmt  = FMT_TWO;
            op   = {{(OP_W-2){1'b0}}, word[13:12]};
            ra   = word[11:8];
            imm8 = word[IMM8_W-1:0];
        end else begin
            fmt  = FMT_THREE;
            op   = {{(OP_W-4){1'b0}}, word[13:10]};
            disp = disp_scaled;
        end
    end
endmodule

// File: rtl/vlid_long_table.sv
// Format 1 table: maps the 8-bit operation code to class, length, legality,
// exception code and the shift flag. Assumes the code came from a word with
// bit 15 clear, so only codes below 0x80 occur.
module vlid_long_table
    import vlid_pkg::*;
(
    input  logic [OP_W-1:0] op,
    output op_attr_t        attr
);
    logic [NCLS-1:0] cls_v;
    logic            known;

    // Class lookup; unknown codes fall through to not-known.
    always_comb begin
        cls_v = '0;
        known = 1'b1;
        unique case (op) inside
            8'h07, 8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D,
            8'h21, 8'h22, 8'h36, 8'h38:           cls_v[CLS_LOAD]  = 1'b1;
            8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F,
            8'h23, 8'h24, 8'h37, 8'h39:           cls_v[CLS_STORE] = 1'b1;
            8'h03, 8'h19:                         cls_v[CLS_CALL]  = 1'b1;
            8'h04:                                cls_v[CLS_RET]   = 1'b1;
            8'h1A, 8'h25:                         cls_v[CLS_JUMP]  = 1'b1;
            8'h30, 8'h35:                         cls_v[CLS_EXC]   = 1'b1;
            8'h00, 8'h01, 8'h02, 8'h05, 8'h0E, 8'h1B,
            8'h20, [8'h26:8'h2F], [8'h31:8'h34]:  cls_v[CLS_ALU]   = 1'b1;
            default:                              known = 1'b0;
        endcase
    end

    // Length, exception and shift attributes of known codes.
    always_comb begin
        if (!known) begin
            attr = illegal_attr();
        end else begin
            attr.cls   = cls_v;
            attr.legal = 1'b1;
            attr.long_form = (op inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C,
                                         8'h0D, 8'h1A, 8'h1B, 8'h1D, 8'h1F,
                                         8'h20, 8'h22, 8'h24, 8'h30,
                                         [8'h36:8'h39]});
            attr.shift5 = (op inside {8'h27, 8'h28, 8'h2D});
            attr.exc    = (op == 8'h30) ? EXC_SWI :
                          (op == 8'h35) ? EXC_BREAK : EXC_NONE;
        end
    end
endmodule

// File: rtl/vlid_short_table.sv
// Tables for format 2 (register plus value) and format 3 (branch). Both are
// always 2 bytes long. Assumes op holds the zero-extended code of its format.
module vlid_short_table
    import vlid_pkg::*;
#(
    parameter int NUM_BR_CONDS = 10
) (
    input  fmt_e            fmt,
    input  logic [OP_W-1:0] op,
    output op_attr_t        attr
);
    // Attribute selection for the two short formats.
    always_comb begin
        attr           = '0;
        attr.legal     = 1'b1;
        attr.exc       = EXC_NONE;
        attr.long_form = 1'b0;
        attr.shift5    = 1'b0;
        if (fmt == FMT_TWO) begin
            if (op[1]) attr.cls[CLS_SREG] = 1'b1;
            else       attr.cls[CLS_ALU]  = 1'b1;
        end else if (int'(op) < NUM_BR_CONDS) begin
            attr.cls[CLS_BR] = 1'b1;
        end else begin
            attr = illegal_attr();
        end
    end
endmodule

// File: rtl/vl_instr_decoder.sv
// Top: decodes a strobed 16-bit word into a registered bundle, valid with
// out_done one cycle after in_valid; the bundle holds between strobes.
// Assumes one word per strobe; the 32-bit immediate is fetched elsewhere.
module vl_instr_decoder
    import vlid_pkg::*;
#(
    parameter int SHORT_LEN = 2,
    parameter int LONG_LEN  = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [WORD_W-1:0]   in_word,
    output logic                out_done,
    output logic [1:0]          out_fmt,
    output logic [OP_W-1:0]     out_op,
    output logic [REG_W-1:0]    out_ra,
    output logic [REG_W-1:0]    out_rb,
    output logic [IMM8_W-1:0]   out_imm8,
    output logic [DISP_W-1:0]   out_disp,
    output logic [NCLS-1:0]     out_cls,
    output logic [LEN_W-1:0]    out_len,
    output logic                out_need_imm,
    output logic                out_illegal,
    output logic [1:0]          out_exc,
    output logic                out_shift5
);
    fmt_e              fmt_c;
    logic [OP_W-1:0]   op_c;
    logic [REG_W-1:0]  ra_c, rb_c;
    logic [IMM8_W-1:0] imm8_c;
    logic [DISP_W-1:0] disp_c;
    op_attr_t          long_attr, short_attr, sel_attr;

    vlid_field_split u_split (
        .word (in_word),
        .fmt  (fmt_c),
        .op   (op_c),
        .ra   (ra_c),
        .rb   (rb_c),
        .imm8 (imm8_c),
        .disp (disp_c)
    );

    vlid_long_table u_long (
        .op   (op_c),
        .attr (long_attr)
    );

    vlid_short_table u_short (
        .fmt  (fmt_c),
        .op   (op_c),
        .attr (short_attr)
    );

    // Pick the table that owns the detected format.
    always_comb begin
        sel_attr = (fmt_c == FMT_ONE) ? long_attr : short_attr;
    end

    // Done strobe: one cycle after each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) out_done <= 1'b0;
        else        out_done <= in_valid;
    end

    // Bundle register: load on strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_fmt      <= '0;
            out_op       <= '0;
            out_ra       <= '0;
            out_rb       <= '0;
            out_imm8     <= '0;
            out_disp     <= '0;
            out_cls      <= '0;
            out_len      <= '0;
            out_need_imm <= 1'b0;
            out_illegal  <= 1'b0;
            out_exc      <= '0;
            out_shift5   <= 1'b0;
        end else if (in_valid) begin
            out_fmt      <= fmt_c;
            out_op       <= op_c;
            out_ra       <= ra_c;
            out_rb       <= rb_c;
            out_imm8     <= imm8_c;
            out_disp     <= disp_c;
            out_cls      <= sel_attr.cls;
            out_len      <= sel_attr.long_form ? LEN_W'(LONG_LEN) : LEN_W'(SHORT_LEN);
            out_need_imm <= sel_attr.long_form;
            out_illegal  <= !sel_attr.legal;
            out_exc      <= sel_attr.exc;
            out_shift5   <= sel_attr.shift5;
        end
    end
endmodule

// File: rtl/vl_instr_decoder_chk.sv
// Checker: temporal and consistency properties of the decoder ports.
module vl_instr_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_valid,
    input logic        out_done,
    input logic [1:0]  out_fmt,
    input logic [7:0]  out_op,
    input logic [8:0]  out_cls,
    input logic [2:0]  out_len,
    input logic        out_need_imm,
    input logic        out_illegal,
    input logic [1:0]  out_exc
);
    p_done_after_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_done);
    p_no_spurious_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_done);
    p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(out_op) && $stable(out_cls) && $stable(out_len)));
    p_cls_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> $countones(out_cls) == 1);
    p_len_vs_imm_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> ((out_len == 3'd6) == out_need_imm));
    p_illegal_trap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_illegal |-> (out_exc == 2'd1 && out_cls[8] && out_len == 3'd2));
    p_fmt_known_r1: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |-> out_fmt != 2'd0);
endmodule

bind vl_instr_decoder vl_instr_decoder_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .out_done     (out_done),
    .out_fmt      (out_fmt),
    .out_op       (out_op),
    .out_cls      (out_cls),
    .out_len      (out_len),
    .out_need_imm (out_need_imm),
    .out_illegal  (out_illegal),
    .out_exc      (out_exc)
);

// File: tb/tb_vl_instr_decoder.sv
module tb_vl_instr_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        out_done, out_need_imm, out_illegal, out_shift5;
    logic [1:0]  out_fmt, out_exc;
    logic [7:0]  out_op, out_imm8;
    logic [3:0]  out_ra, out_rb;
    logic [15:0] out_disp;
    logic [8:0]  out_cls;
    logic [2:0]  out_len;
    int n_checks = 0;
    int n_errs   = 0;

    always #2.5 clk = ~clk;

    vl_instr_decoder dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .out_done(out_done), .out_fmt(out_fmt), .out_op(out_op),
        .out_ra(out_ra), .out_rb(out_rb), .out_imm8(out_imm8),
        .out_disp(out_disp), .out_cls(out_cls), .out_len(out_len),
        .out_need_imm(out_need_imm), .out_illegal(out_illegal),
        .out_exc(out_exc), .out_shift5(out_shift5)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp, input logic [15:0] w);
        n_checks++;
        if (got !== exp) begin
            n_errs++;
            $display("FAIL %s word=%h actual=%h expected=%h", req, w, got, exp);
        end
    endtask

    // Reference model built from the requirement text.
    function automatic logic f1_legal(input logic [7:0] op);
        return (op <= 8'h0E) || (op >= 8'h19 && op <= 8'h39);
    endfunction

    function automatic logic e_illegal(input logic [15:0] w);
        if (!w[15])     return !f1_legal(w[15:8]);
        else if (w[14]) return w[13:10] > 4'd9;
        else            return 1'b0;
    endfunction

    function automatic logic e_long(input logic [15:0] w);
        return !w[15] && (w[15:8] inside {8'h01, 8'h03, 8'h08, 8'h09, 8'h0C, 8'h0D,
            8'h1A, 8'h1B, 8'h1D, 8'h1F, 8'h20, 8'h22, 8'h24, 8'h30,
            8'h36, 8'h37, 8'h38, 8'h39});
    endfunction

    function automatic logic [8:0] e_cls(input logic [15:0] w);
        logic [7:0] op = w[15:8];
        if (e_illegal(w)) return 9'h100;
        if (w[15]) return w[14] ? 9'h008 : (w[13] ? 9'h080 : 9'h001);
        if (op inside {8'h07, 8'h08, 8'h0A, 8'h0C, 8'h1C, 8'h1D, 8'h21, 8'h22, 8'h36, 8'h38}) return 9'h002;
        if (op inside {8'h06, 8'h09, 8'h0B, 8'h0D, 8'h1E, 8'h1F, 8'h23, 8'h24, 8'h37, 8'h39}) return 9'h004;
        if (op inside {8'h03, 8'h19}) return 9'h020;
        if (op == 8'h04) return 9'h040;
        if (op inside {8'h1A, 8'h25}) return 9'h010;
        if (op inside {8'h30, 8'h35}) return 9'h100;
        return 9'h001;
    endfunction

    function automatic logic [1:0] e_exc(input logic [15:0] w);
        if (e_illegal(w)) return 2'd1;
        if (!w[15] && w[15:8] == 8'h30) return 2'd2;
        if (!w[15] && w[15:8] == 8'h35) return 2'd3;
        return 2'd0;
    endfunction

    task automatic apply(input logic [15:0] w);
        logic [15:0] d;
        @(negedge clk);
        in_valid = 1'b1;
        in_word  = w;
        @(negedge clk);
        in_valid = 1'b0;
        in_word  = $urandom;
        chk("R10 done", out_done, 1, w);
        if (!w[15]) begin
            chk("R1 fmt", out_fmt, 1, w);
            chk("R2 op", out_op, w[15:8], w);
            chk("R2 ra", out_ra, w[7:4], w);
            chk("R2 rb", out_rb, w[3:0], w);
            chk("R2 imm/disp", {out_imm8, out_disp}, 0, w);
        end else if (!w[14]) begin
            chk("R1 fmt", out_fmt, 2, w);
            chk("R3 op", out_op, w[13:12], w);
            chk("R3 ra", out_ra, w[11:8], w);
            chk("R3 imm8", out_imm8, w[7:0], w);
            chk("R3 rb/disp", {out_rb, out_disp}, 0, w);
        end else begin
            d = {{5{w[9]}}, w[9:0], 1'b0};
            chk("R1 fmt", out_fmt, 3, w);
            chk("R4 op", out_op, w[13:10], w);
            chk("R4 disp", out_disp, d, w);
            chk("R4 ra/rb/imm8", {out_ra, out_rb, out_imm8}, 0, w);
        end
        chk("R5 illegal", out_illegal, e_illegal(w), w);
        chk("R6 len", out_len, e_long(w) ? 6 : 2, w);
        chk("R6 need_imm", out_need_imm, e_long(w), w);
        chk("R7 cls", out_cls, e_cls(w), w);
        chk("R8 exc", out_exc, e_exc(w), w);
        chk("R9 shift5", out_shift5, (!w[15] && (w[15:8] inside {8'h27, 8'h28, 8'h2D})), w);
        @(negedge clk);
        chk("R10 single done", out_done, 0, w);
        chk("R10 hold op", out_op, w[15] ? (w[14] ? {4'b0, w[13:10]} : {6'b0, w[13:12]}) : w[15:8], w);
        chk("R10 hold cls", out_cls, e_cls(w), w);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin : stim
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        chk("R11 done", out_done, 0, 16'h0);
        chk("R11 bundle", {out_fmt, out_op, out_ra, out_rb, out_imm8, out_cls,
                           out_len, out_need_imm, out_illegal, out_exc, out_shift5}, 0, 16'h0);
        chk("R11 disp", out_disp, 0, 16'h0);
        rst_n = 1'b1;
        // Directed: every format 1 code, covering legal-range edges.
        for (int op = 0; op < 128; op++) apply({op[7:0], 8'($urandom)});
        // Format 2 codes and format 3 conditions including 9/10 edge.
        for (int c = 0; c < 4; c++) apply({2'b10, c[1:0], 12'($urandom)});
        for (int c = 0; c < 16; c++) apply({2'b11, c[3:0], 10'($urandom)});
        // Displacement extremes.
        apply(16'hC1FF);
        apply(16'hC200);
        apply(16'hC3FF);
        apply(16'hC000);
        // Random words, with back-to-back strobes now and then.
        for (int i = 0; i < 400; i++) begin
            if (i % 7 == 0) begin
                @(negedge clk);
                in_valid = 1'b1;
                in_word  = $urandom;
            end
            apply(16'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule